// File: doc/BRIEF.md
# Pattern-Memory Bank Router with Embedded Tile RAM

This block sits between a picture processor's pattern-table fetch port and the cartridge's character memory. The pattern space is cut into 1 KiB slots, and each slot has its own 8-bit bank register. The host CPU loads each register as two 4-bit halves through a small write port. Each half has its own address inside four consecutive 4 KiB CPU pages, and each page holds two slots.

On every pattern access, the block looks up the register for the slot being addressed. Two bank values are reserved: 4 and 5. A slot holding either of them is served from a private 2 KiB tile RAM. Value 4 selects the lower kilobyte and value 5 the upper kilobyte, and writes to such a slot are stored. Every other bank value produces a ROM address, and writes to that slot are thrown away.

Pattern accesses travel as a request stream and a response stream, both valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Its response appears on the following cycle and is held unchanged while `rsp_ready` is low. `req_ready` is high whenever the response slot is empty or is being emptied in the same cycle. A stalled consumer therefore stalls the producer after one request, and a consumer that keeps `rsp_ready` high gets one access per cycle.

Top module: `chr_bank_router`

## Requirements
- R1: After reset, every bank register is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A CPU write on `cfg_we` that hits a register loads `cfg_nibble` into one half of one bank register. The page is `cfg_addr[15:12]`, where 0xB to 0xE select pages 0 to 3, and page p holds slots 2p and 2p+1. `cfg_addr[3]` = 1 selects the odd slot, and `cfg_addr[2]` = 1 selects bits 7:4 (0 selects bits 3:0). The other half of the register keeps its value.
- R3: A CPU write whose page lies outside 0xB to 0xE, or whose `cfg_addr` bits 11:4 or 1:0 are not all zero, changes no register.
- R4: For a pattern request, `req_addr[12:10]` selects the slot and `req_addr[9:0]` is the offset inside it. The response's `rsp_rom_addr[9:0]` always equals that offset.
- R5: When the slot's bank value is neither 4 nor 5, the response has `rsp_is_ram` = 0, `rsp_rom_addr` = {bank value, offset} (18 bits), and `rsp_data` = 0. Values 3, 6 and any value with a non-zero upper half, such as 0x14, take this path.
- R6: When the bank value is 4 or 5, the response has `rsp_is_ram` = 1. `rsp_data` holds tile RAM byte (bank-4)*1024 + offset as it stood before this request.
- R7: A write request to a RAM-mapped slot stores `req_wdata` and returns `rsp_wr_ok` = 1. A write request to a ROM-mapped slot returns `rsp_wr_ok` = 0 and leaves the tile RAM unchanged.
- R8: The two RAM kilobytes are independent. Different slots holding the same RAM bank value see the same bytes.
- R9: A request accepted on an edge gives `rsp_valid` = 1 after that edge. While `rsp_valid` = 1 and `rsp_ready` = 0, `req_ready` is 0 and the response fields do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | CPU register write strobe |
| cfg_addr | input | 16 | CPU write address |
| cfg_nibble | input | 4 | CPU write data (one register half) |
| req_valid | input | 1 | Pattern request valid |
| req_ready | output | 1 | Pattern request accepted when high |
| req_addr | input | 13 | Pattern address (slot and offset) |
| req_we | input | 1 | Request is a write |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_is_ram | output | 1 | Access was served by the tile RAM |
| rsp_wr_ok | output | 1 | Write request was stored |
| rsp_rom_addr | output | 18 | ROM address {bank, offset} |
| rsp_data | output | 8 | Tile RAM read data, 0 on ROM path |

## Verification
The bench builds the block with its default parameters: eight slots, 8-bit banks, 10-bit offsets, a RAM window starting at value 4 and two RAM kilobytes, and register pages starting at 0xB. These values let the bench write both halves of a register and reach all four register pages, including the first and last slot. Because the full 8-bit value is compared, the bench can show that 0x14 stays on the ROM path, and it can cross the 3/4 and 5/6 boundaries of the RAM window. The stimulus table addresses offset 0x3FF and slot 7, and the directed cases cover aliasing between slots and a stalled response stream.

// File: rtl/chr_bank_pkg.sv
package chr_bank_pkg;

  typedef enum logic {
    NIB_LO = 1'b0,
    NIB_HI = 1'b1
  } nib_sel_e;

  // Register addresses carry no bits besides page, slot parity and half select.
  function automatic logic cfg_aux_clear(input logic [15:0] a);
    return (a[11:4] == 8'h00) && (a[1:0] == 2'b00);
  endfunction

endpackage

// File: rtl/chr_bank_regs.sv
module chr_bank_regs
  import chr_bank_pkg::*;
#(
  parameter int SLOTS      = 8,
  parameter int BANK_W     = 8,
  parameter int PAGE_FIRST = 11,
  localparam int NIB_W     = BANK_W / 2,
  localparam int PAGES     = SLOTS / 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [15:0]               cfg_addr,
  input  logic [NIB_W-1:0]          cfg_nibble,
  output logic [SLOTS*BANK_W-1:0]   bank_flat
);

  logic       addr_ok;
  nib_sel_e   half;
  logic [3:0] page_num;

  assign addr_ok  = cfg_we && cfg_aux_clear(cfg_addr);
  assign half     = nib_sel_e'(cfg_addr[2]);
  assign page_num = cfg_addr[15:12];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam logic [3:0] MY_PAGE = 4'(PAGE_FIRST + s / 2);
    localparam logic       MY_ODD  = 1'(s % 2);
    logic                  hit;
    logic [BANK_W-1:0]     bank_q;

    assign hit = addr_ok && (page_num == MY_PAGE) && (cfg_addr[3] == MY_ODD);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bank_q <= '0;
      end else if (hit) begin
        if (half == NIB_HI) bank_q[BANK_W-1:NIB_W] <= cfg_nibble;
        else                bank_q[NIB_W-1:0]      <= cfg_nibble;
      end
    end

    assign bank_flat[s*BANK_W +: BANK_W] = bank_q;
  end

endmodule

// File: rtl/chr_route.sv
module chr_route #(
  parameter int SLOTS     = 8,
  parameter int BANK_W    = 8,
  parameter int OFS_W     = 10,
  parameter int RAM_FIRST = 4,
  parameter int RAM_BANKS = 2,
  localparam int SLOT_W   = $clog2(SLOTS),
  localparam int PPU_AW   = SLOT_W + OFS_W,
  localparam int ROM_AW   = BANK_W + OFS_W,
  localparam int RAM_BW   = $clog2(RAM_BANKS),
  localparam int RAM_AW   = RAM_BW + OFS_W
) (
  input  logic [SLOTS*BANK_W-1:0] bank_flat,
  input  logic [PPU_AW-1:0]       ppu_addr,
  output logic                    is_ram,
  output logic [RAM_AW-1:0]       ram_idx,
  output logic [ROM_AW-1:0]       rom_addr
);

  localparam logic [BANK_W-1:0] RAM_LO  = BANK_W'(RAM_FIRST);
  localparam logic [BANK_W-1:0] RAM_CNT = BANK_W'(RAM_BANKS);

  logic [BANK_W-1:0] bank_arr [SLOTS];
  logic [SLOT_W-1:0] slot;
  logic [OFS_W-1:0]  ofs;
  logic [BANK_W-1:0] bank;
  logic [BANK_W-1:0] rel;

  for (genvar s = 0; s < SLOTS; s++) begin : g_unpack
    assign bank_arr[s] = bank_flat[s*BANK_W +: BANK_W];
  end

  assign slot = ppu_addr[PPU_AW-1:OFS_W];
  assign ofs  = ppu_addr[OFS_W-1:0];
  assign bank = bank_arr[slot];

  // Unsigned wrap sends values below the window far above RAM_CNT.
  assign rel      = bank - RAM_LO;
  assign is_ram   = (rel < RAM_CNT);
  assign ram_idx  = {rel[RAM_BW-1:0], ofs};
  assign rom_addr = {bank, ofs};

endmodule

// File: rtl/chr_ram.sv
module chr_ram #(
  parameter int AW    = 11,
  parameter int DW    = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  // Read-first: the returned byte is the content before this access.
  always_ff @(posedge clk) begin
    if (en) begin
      rdata <= mem[idx];
      if (we) mem[idx] <= wdata;
    end
  end

endmodule

// File: rtl/chr_bank_router.sv
module chr_bank_router #(
  parameter int SLOTS      = 8,
  parameter int BANK_W     = 8,
  parameter int OFS_W      = 10,
  parameter int DATA_W     = 8,
  parameter int RAM_FIRST  = 4,
  parameter int RAM_BANKS  = 2,
  parameter int PAGE_FIRST = 11,
  localparam int SLOT_W    = $clog2(SLOTS),
  localparam int PPU_AW    = SLOT_W + OFS_W,
  localparam int ROM_AW    = BANK_W + OFS_W,
  localparam int NIB_W     = BANK_W / 2,
  localparam int RAM_AW    = $clog2(RAM_BANKS) + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [15:0]       cfg_addr,
  input  logic [NIB_W-1:0]  cfg_nibble,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PPU_AW-1:0] req_addr,
  input  logic              req_we,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_is_ram,
  output logic              rsp_wr_ok,
  output logic [ROM_AW-1:0] rsp_rom_addr,
  output logic [DATA_W-1:0] rsp_data
);

  logic [SLOTS*BANK_W-1:0] bank_flat;
  logic                    route_ram;
  logic [RAM_AW-1:0]       route_idx;
  logic [ROM_AW-1:0]       route_rom;
  logic                    accept;
  logic                    ram_we;
  logic [DATA_W-1:0]       ram_rdata;

  chr_bank_regs #(
    .SLOTS(SLOTS), .BANK_W(BANK_W), .PAGE_FIRST(PAGE_FIRST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_nibble(cfg_nibble), .bank_flat(bank_flat)
  );

  chr_route #(
    .SLOTS(SLOTS), .BANK_W(BANK_W), .OFS_W(OFS_W),
    .RAM_FIRST(RAM_FIRST), .RAM_BANKS(RAM_BANKS)
  ) u_route (
    .bank_flat(bank_flat), .ppu_addr(req_addr), .is_ram(route_ram),
    .ram_idx(route_idx), .rom_addr(route_rom)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign ram_we    = accept && req_we && route_ram;

  chr_ram #(.AW(RAM_AW), .DW(DATA_W)) u_ram (
    .clk(clk), .en(accept), .we(ram_we), .idx(route_idx),
    .wdata(req_wdata), .rdata(ram_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_is_ram   <= 1'b0;
      rsp_wr_ok    <= 1'b0;
      rsp_rom_addr <= '0;
    end else if (accept) begin
      rsp_valid    <= 1'b1;
      rsp_is_ram   <= route_ram;
      rsp_wr_ok    <= req_we && route_ram;
      rsp_rom_addr <= route_rom;
    end else if (rsp_ready) begin
      rsp_valid    <= 1'b0;
    end
  end

  assign rsp_data = rsp_is_ram ? ram_rdata : '0;

endmodule

// File: rtl/chr_bank_router_chk.sv
module chr_bank_router_chk #(
  parameter int SLOTS      = 8,
  parameter int BANK_W     = 8,
  parameter int OFS_W      = 10,
  parameter int PAGE_FIRST = 11,
  localparam int PPU_AW    = $clog2(SLOTS) + OFS_W,
  localparam int ROM_AW    = BANK_W + OFS_W,
  localparam int NIB_W     = BANK_W / 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cfg_we,
  input logic [15:0]             cfg_addr,
  input logic [NIB_W-1:0]        cfg_nibble,
  input logic                    req_valid,
  input logic                    req_ready,
  input logic [PPU_AW-1:0]       req_addr,
  input logic                    rsp_valid,
  input logic                    rsp_ready,
  input logic                    rsp_is_ram,
  input logic                    rsp_wr_ok,
  input logic [ROM_AW-1:0]       rsp_rom_addr,
  input logic [SLOTS*BANK_W-1:0] bank_flat
);

  localparam logic [3:0] PG_LO = 4'(PAGE_FIRST);
  localparam logic [3:0] PG_HI = 4'(PAGE_FIRST + SLOTS / 2 - 1);

  // R2
  hi_half_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_addr == {PG_LO, 12'h004}
    |=> bank_flat[BANK_W-1:NIB_W] == $past(cfg_nibble));

  // R3
  off_page_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && (cfg_addr[15:12] < PG_LO || cfg_addr[15:12] > PG_HI)
    |=> bank_flat == $past(bank_flat));

  // R4
  offset_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_rom_addr[OFS_W-1:0] == $past(req_addr[OFS_W-1:0]));

  // R7
  rom_write_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_wr_ok |-> rsp_is_ram);

  // R9
  accept_gives_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rom_addr)
      && $stable(rsp_is_ram) && $stable(rsp_wr_ok));

endmodule

bind chr_bank_router chr_bank_router_chk #(
  .SLOTS(SLOTS), .BANK_W(BANK_W), .OFS_W(OFS_W), .PAGE_FIRST(PAGE_FIRST)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_nibble(cfg_nibble), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_is_ram(rsp_is_ram), .rsp_wr_ok(rsp_wr_ok),
  .rsp_rom_addr(rsp_rom_addr), .bank_flat(bank_flat)
);

// File: tb/chr_bank_router_tb_top.sv
module chr_bank_router_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_addr = '0;
  logic [3:0]  cfg_nibble = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [12:0] req_addr = '0;
  logic        req_we = 1'b0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_is_ram;
  logic        rsp_wr_ok;
  logic [17:0] rsp_rom_addr;
  logic [7:0]  rsp_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  chr_bank_router dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_nibble(cfg_nibble), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_is_ram(rsp_is_ram),
    .rsp_wr_ok(rsp_wr_ok), .rsp_rom_addr(rsp_rom_addr), .rsp_data(rsp_data)
  );

  // Register-write vectors, applied in order; each is followed by one read.
  localparam int NV = 11;
  localparam logic [15:0] V_CA [NV] = '{16'hB000, 16'hB004, 16'hB008, 16'hB00C,
    16'hC000, 16'hE00C, 16'hE008, 16'hA000, 16'hF008, 16'hD004, 16'hB010};
  localparam logic [3:0]  V_NB [NV] = '{4'h3, 4'h2, 4'h6, 4'h7, 4'h9, 4'h1,
    4'h2, 4'h5, 4'h5, 4'hA, 4'h9};
  localparam logic [12:0] V_PA [NV] = '{13'h0005, 13'h0010, 13'h07FF, 13'h0401,
    13'h0800, 13'h1FFF, 13'h1C00, 13'h0000, 13'h1C02, 13'h1000, 13'h0001};
  localparam logic [17:0] V_RA [NV] = '{18'h00C05, 18'h08C10, 18'h01BFF, 18'h1D801,
    18'h02400, 18'h043FF, 18'h04800, 18'h08C00, 18'h04802, 18'h28000, 18'h08C01};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [15:0] a, input logic [3:0] n);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_nibble = n;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic ppu_op(input logic [12:0] a, input logic we, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_we = we; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] hold_data;
    logic [17:0] hold_addr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 req_ready", 32'(req_ready), 32'd1);
    ppu_op(13'h0C33, 1'b0, 8'h00);
    chk("R1 bank zero", 32'(rsp_rom_addr), 32'h00033);
    chk("R9 rsp_valid after accept", 32'(rsp_valid), 32'd1);

    // R2 R3 R4 R5 table walk
    for (int i = 0; i < NV; i++) begin
      cfg_wr(V_CA[i], V_NB[i]);
      ppu_op(V_PA[i], 1'b0, 8'h00);
      chk("R2/R3 rom addr", 32'(rsp_rom_addr), 32'(V_RA[i]));
      chk("R5 is_ram", 32'(rsp_is_ram), 32'd0);
      chk("R5 data zero", 32'(rsp_data), 32'd0);
    end

    // R6 R8 RAM banks: slot0 -> 4, slot1 -> 5
    cfg_wr(16'hB000, 4'h4); cfg_wr(16'hB004, 4'h0);
    cfg_wr(16'hB008, 4'h5); cfg_wr(16'hB00C, 4'h0);
    ppu_op(13'h0000, 1'b1, 8'h11);
    chk("R7 wr_ok ram", 32'(rsp_wr_ok), 32'd1);
    chk("R6 is_ram bank4", 32'(rsp_is_ram), 32'd1);
    ppu_op(13'h0400, 1'b1, 8'h22);
    chk("R6 is_ram bank5", 32'(rsp_is_ram), 32'd1);
    ppu_op(13'h0000, 1'b0, 8'h00);
    chk("R8 bank4 byte", 32'(rsp_data), 32'h11);
    ppu_op(13'h0400, 1'b0, 8'h00);
    chk("R8 bank5 byte", 32'(rsp_data), 32'h22);
    ppu_op(13'h07FF, 1'b1, 8'h5A);
    ppu_op(13'h07FF, 1'b0, 8'h00);
    chk("R6 last byte", 32'(rsp_data), 32'h5A);
    chk("R4 offset", 32'(rsp_rom_addr[9:0]), 32'h3FF);

    // R7 bank 3 stays ROM, write refused
    cfg_wr(16'hC000, 4'h3); cfg_wr(16'hC004, 4'h0);
    ppu_op(13'h0800, 1'b1, 8'hFF);
    chk("R7 wr_ok rom", 32'(rsp_wr_ok), 32'd0);
    chk("R5 bank3 rom", 32'(rsp_is_ram), 32'd0);
    chk("R5 bank3 addr", 32'(rsp_rom_addr), 32'h00C00);
    // R8 alias: slot2 -> 4 sees byte 0 of bank 4, untouched by the ROM write
    cfg_wr(16'hC000, 4'h4);
    ppu_op(13'h0800, 1'b0, 8'h00);
    chk("R8 alias slot2", 32'(rsp_data), 32'h11);
    ppu_op(13'h0000, 1'b1, 8'h33);
    ppu_op(13'h0800, 1'b0, 8'h00);
    chk("R8 alias follows write", 32'(rsp_data), 32'h33);
    // R5 bank 6 and 0x14 are ROM
    cfg_wr(16'hC000, 4'h6);
    ppu_op(13'h0800, 1'b1, 8'h77);
    chk("R5 bank6 rom", 32'(rsp_is_ram), 32'd0);
    chk("R7 bank6 wr_ok", 32'(rsp_wr_ok), 32'd0);
    cfg_wr(16'hC000, 4'h4); cfg_wr(16'hC004, 4'h1);
    ppu_op(13'h0800, 1'b0, 8'h00);
    chk("R5 bank14 rom", 32'(rsp_is_ram), 32'd0);
    chk("R5 bank14 addr", 32'(rsp_rom_addr), 32'h05000);
    ppu_op(13'h0000, 1'b0, 8'h00);
    chk("R7 ram after rom writes", 32'(rsp_data), 32'h33);

    // R9 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_addr = 13'h0400;
    @(negedge clk);
    req_addr = 13'h0000;
    chk("R9 ready low on stall", 32'(req_ready), 32'd0);
    hold_data = rsp_data; hold_addr = rsp_rom_addr;
    chk("R9 stalled data", 32'(hold_data), 32'h22);
    @(negedge clk);
    chk("R9 held valid", 32'(rsp_valid), 32'd1);
    chk("R9 held data", 32'(rsp_data), 32'(hold_data));
    chk("R9 held addr", 32'(rsp_rom_addr), 32'(hold_addr));
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 next accepted", 32'(rsp_data), 32'h33);
    chk("R9 next valid", 32'(rsp_valid), 32'd1);
    @(negedge clk);
    chk("R9 drained", 32'(rsp_valid), 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule